// File: doc/BRIEF.md
# DRAM Refresh and Wake-up Sequencer

This block keeps the contents of an asynchronous DRAM alive. It runs from a free-running system clock. Every analog limit (strobe setup, hold, active and precharge widths, the power-up pause and the retention window) enters as a nanosecond parameter and is turned into a whole number of clock cycles. Short limits are rounded up to whole cycles. The refresh interval is rounded down, so that rounding never stretches the retention window.

After reset the block waits out the power-up pause. It then asks for the strobes and issues a fixed number of wake-up refresh cycles, and only then raises `init_done`. After that it counts refresh intervals and raises one request per interval. An arbiter that shares the strobes with an access controller may postpone refreshes up to a limit. When the limit is reached, an urgency flag goes up. If one more interval passes unserved, the retention guarantee is gone: `init_done` drops and the whole wake-up burst is repeated.

Each cycle begins only on a grant. By default it is a CAS-before-RAS cycle: both byte CAS strobes fall first, RAS falls after the setup window, CAS is held through the hold window, and RAS stays low for the active width. A parameter instead selects RAS-only refresh, which drives an internal row counter onto the address pins with CAS kept high. Write enable stays high throughout, and the done pulse marks the end of the RAS precharge.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n`, `casl_n`, `cash_n` and `we_n` are 1, and `ref_req`, `ref_done`, `ref_urgent` and `init_done` are 0.
- R2: `ref_req` stays low for the first PWRUP_CYC-1 clock edges after reset is released, and is high after edge PWRUP_CYC, where PWRUP_CYC = ceil(PWRUP_NS/CLK_NS).
- R3: `init_done` stays 0 until WAKE_CYCLES refresh cycles have completed, and becomes 1 in the cycle after the last of them signals `ref_done`.
- R4: A refresh cycle starts only on a clock edge at which both `ref_req` and `ref_grant` are 1; the strobes change in the next cycle. A grant while `ref_req` is 0 leaves all strobes high and produces no `ref_done`.
- R5: In CAS-before-RAS mode, `casl_n` and `cash_n` fall together and stay low for exactly ceil(T_CSR_NS/CLK_NS) cycles before `ras_n` falls.
- R6: In CAS-before-RAS mode, both CAS strobes rise exactly ceil(T_CHR_NS/CLK_NS) cycles after `ras_n` falls, while `ras_n` is still low.
- R7: `ras_n` stays low for max(ceil(T_RAS_NS/CLK_NS), the hold count) cycles and then stays high for max(ceil(T_RP_NS/CLK_NS), ceil(T_RPC_NS/CLK_NS)) cycles before `ref_done`.
- R8: `we_n` is 1 in every cycle.
- R9: `ref_done` is a one-cycle pulse that appears only when `ras_n` is high and the precharge count is complete.
- R10: After `init_done` rises, the first refresh request appears exactly REFI_CYC cycles later, where REFI_CYC = floor(RETENTION_NS / 2^ROW_W / CLK_NS).
- R11: Unserved intervals accumulate. `ref_urgent` is 1 exactly when MAX_POSTPONE intervals are pending, and it clears in the cycle after a serviced refresh reduces the pending count.
- R12: An interval that elapses while MAX_POSTPONE are already pending clears `init_done` in that cycle. `ref_req` stays high, and WAKE_CYCLES further refreshes are needed before `init_done` returns.
- R13: With RAS_ONLY=1, both CAS strobes stay high. `row_addr` is set at least ceil(T_ASR_NS/CLK_NS) (minimum 1) cycles before `ras_n` falls and is held while `ras_n` is low. It starts at row 0 and advances by one per completed cycle, wrapping after 2^ROW_W rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_req | output | 1 | Asks the arbiter for the strobes |
| ref_grant | input | 1 | Arbiter grants the strobes for one refresh cycle |
| ref_done | output | 1 | One-cycle pulse when the strobes are released after precharge |
| ref_urgent | output | 1 | Postponement limit reached |
| init_done | output | 1 | Wake-up burst complete, accesses allowed |
| ras_n | output | 1 | Row strobe, active low |
| casl_n | output | 1 | Lower byte column strobe, active low |
| cash_n | output | 1 | Upper byte column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| row_addr | output | ROW_W | Refresh row in RAS-only mode, zero otherwise |

## Verification
The bench measures every strobe edge against the cycle counts. A sequencer that dropped RAS together with CAS, released CAS early, or shortened the precharge would be flagged at the first refresh. It also checks the one-cycle edges of the power-up pause and of the first interval: a counter that is off by one would raise the request a cycle early or late. It holds the grant back to drive the pending count up to the urgency limit and then one interval past it. A design that saturated silently, instead of dropping `init_done` and repeating the wake-up burst, would fail there. A separate RAS-only instance with a small row space runs past the wrap, which exposes a row counter that skips, repeats, or changes while RAS is low.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE,
    ENG_SETUP,
    ENG_ACTIVE,
    ENG_PRECH
  } eng_state_t;

  // Cycles needed to cover a nanosecond limit.
  function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
    return (t_ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ref_interval_tracker.sv
module ref_interval_tracker #(
  parameter int REFI_CYC     = 1953,
  parameter int MAX_POSTPONE = 8,
  localparam int CNT_W = $clog2(REFI_CYC + 1),
  localparam int PND_W = $clog2(MAX_POSTPONE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             served,
  output logic [PND_W-1:0] pend,
  output logic             urgent,
  output logic             overrun
);

  logic [CNT_W-1:0] cnt_q;
  logic [PND_W-1:0] pend_q;
  logic             tick;

  assign tick    = (cnt_q == CNT_W'(REFI_CYC - 1));
  assign overrun = en && tick && !served && (pend_q == PND_W'(MAX_POSTPONE));
  assign pend    = pend_q;
  assign urgent  = (pend_q == PND_W'(MAX_POSTPONE));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      case ({tick, served})
        2'b10: if (pend_q != PND_W'(MAX_POSTPONE)) pend_q <= pend_q + 1'b1;
        2'b01: if (pend_q != '0) pend_q <= pend_q - 1'b1;
        default: ;
      endcase
    end
  end

  // R11
  pend_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pend_q <= PND_W'(MAX_POSTPONE));

  // R10
  interval_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !served && pend_q != PND_W'(MAX_POSTPONE)) |=> (pend_q <= $past(pend_q) + 1'b1));

endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [ROW_W-1:0] row
);

  always_ff @(posedge clk) begin
    if (rst) row <= '0;
    else if (step) row <= row + 1'b1;
  end

endmodule

// File: rtl/ref_cycle_engine.sv
module ref_cycle_engine
  import dram_ref_pkg::*;
#(
  parameter int ROW_W     = 9,
  parameter bit RAS_ONLY  = 1'b0,
  parameter int SETUP_CYC = 2,
  parameter int HOLD_CYC  = 2,
  parameter int ACT_CYC   = 5,
  parameter int PRE_CYC   = 4,
  localparam int MAXC = imax(imax(SETUP_CYC, ACT_CYC), PRE_CYC),
  localparam int CW   = imax(1, $clog2(MAXC + 1))
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ROW_W-1:0] row_in,
  output logic             busy,
  output logic             done,
  output logic             ras_n,
  output logic             casl_n,
  output logic             cash_n,
  output logic [ROW_W-1:0] addr
);

  eng_state_t       st_q;
  logic [CW-1:0]    cnt_q;
  logic             ras_q, cas_q, done_q;
  logic [ROW_W-1:0] addr_q;
  logic [CW-1:0]    elapsed;

  assign elapsed = CW'(ACT_CYC - 1) - cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ENG_IDLE;
      cnt_q  <= '0;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      done_q <= 1'b0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ENG_IDLE: if (start) begin
          st_q  <= ENG_SETUP;
          cnt_q <= CW'(SETUP_CYC - 1);
          if (RAS_ONLY) addr_q <= row_in;
          else          cas_q  <= 1'b0;
        end
        ENG_SETUP: if (cnt_q == '0) begin
          ras_q <= 1'b0;
          st_q  <= ENG_ACTIVE;
          cnt_q <= CW'(ACT_CYC - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        ENG_ACTIVE: begin
          if (!RAS_ONLY && elapsed == CW'(HOLD_CYC - 1)) cas_q <= 1'b1;
          if (cnt_q == '0) begin
            ras_q <= 1'b1;
            st_q  <= ENG_PRECH;
            cnt_q <= CW'(PRE_CYC - 1);
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ENG_PRECH: if (cnt_q == '0) begin
          done_q <= 1'b1;
          st_q   <= ENG_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end

  assign busy   = (st_q != ENG_IDLE);
  assign done   = done_q;
  assign ras_n  = ras_q;
  assign casl_n = cas_q;
  assign cash_n = cas_q;
  assign addr   = addr_q;

  // R5
  cas_before_ras_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_q) |-> (RAS_ONLY || !cas_q));

  // R7
  ras_rise_prech_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_q) |-> (st_q == ENG_PRECH));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R9
  done_ras_high_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ras_q);

  // R13
  ras_only_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (RAS_ONLY && !ras_q) |-> (cas_q && $stable(addr_q)));

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int CLK_NS       = 8,
  parameter int RETENTION_NS = 8_000_000,
  parameter int ROW_W        = 9,
  parameter int PWRUP_NS     = 100_000,
  parameter int WAKE_CYCLES  = 8,
  parameter int MAX_POSTPONE = 8,
  parameter int T_RAS_NS     = 40,
  parameter int T_RP_NS      = 25,
  parameter int T_RPC_NS     = 10,
  parameter int T_CSR_NS     = 10,
  parameter int T_CHR_NS     = 10,
  parameter int T_ASR_NS     = 0,
  parameter int T_RAH_NS     = 7,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ref_req,
  input  logic             ref_grant,
  output logic             ref_done,
  output logic             ref_urgent,
  output logic             init_done,
  output logic             ras_n,
  output logic             casl_n,
  output logic             cash_n,
  output logic             we_n,
  output logic [ROW_W-1:0] row_addr
);

  localparam int REFI_CYC  = (RETENTION_NS / (1 << ROW_W)) / CLK_NS;
  localparam int PWRUP_CYC = imax(1, ns_to_cyc(PWRUP_NS, CLK_NS));
  localparam int SETUP_CYC = RAS_ONLY ? imax(1, ns_to_cyc(T_ASR_NS, CLK_NS))
                                      : imax(1, ns_to_cyc(T_CSR_NS, CLK_NS));
  localparam int HOLD_CYC  = RAS_ONLY ? imax(1, ns_to_cyc(T_RAH_NS, CLK_NS))
                                      : imax(1, ns_to_cyc(T_CHR_NS, CLK_NS));
  localparam int ACT_CYC   = imax(ns_to_cyc(T_RAS_NS, CLK_NS), HOLD_CYC);
  localparam int PRE_CYC   = imax(1, imax(ns_to_cyc(T_RP_NS, CLK_NS),
                                          ns_to_cyc(T_RPC_NS, CLK_NS)));
  localparam int PWR_W     = $clog2(PWRUP_CYC + 1);
  localparam int WAKE_W    = $clog2(WAKE_CYCLES + 1);
  localparam int PND_W     = $clog2(MAX_POSTPONE + 1);

  logic [PWR_W-1:0]  pwr_cnt_q;
  logic              pwr_ok_q;
  logic [WAKE_W-1:0] wake_left_q;
  logic              init_done_q;
  logic [PND_W-1:0]  pend;
  logic              urgent_raw, overrun;
  logic              eng_busy, eng_done, eng_start;
  logic [ROW_W-1:0]  row_cur;
  logic              need;

  ref_interval_tracker #(
    .REFI_CYC    (REFI_CYC),
    .MAX_POSTPONE(MAX_POSTPONE)
  ) tracker_i (
    .clk    (clk),
    .rst    (rst),
    .en     (init_done_q),
    .served (eng_done && init_done_q),
    .pend   (pend),
    .urgent (urgent_raw),
    .overrun(overrun)
  );

  generate
    if (RAS_ONLY) begin : g_row
      ref_row_counter #(.ROW_W(ROW_W)) row_i (
        .clk (clk),
        .rst (rst),
        .step(eng_done),
        .row (row_cur)
      );
    end else begin : g_norow
      assign row_cur = '0;
    end
  endgenerate

  ref_cycle_engine #(
    .ROW_W    (ROW_W),
    .RAS_ONLY (RAS_ONLY),
    .SETUP_CYC(SETUP_CYC),
    .HOLD_CYC (HOLD_CYC),
    .ACT_CYC  (ACT_CYC),
    .PRE_CYC  (PRE_CYC)
  ) engine_i (
    .clk   (clk),
    .rst   (rst),
    .start (eng_start),
    .row_in(row_cur),
    .busy  (eng_busy),
    .done  (eng_done),
    .ras_n (ras_n),
    .casl_n(casl_n),
    .cash_n(cash_n),
    .addr  (row_addr)
  );

  assign need = init_done_q ? (pend != '0)
                            : (pwr_ok_q && wake_left_q != '0);
  assign eng_start = need && ref_grant && !eng_busy && !eng_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_cnt_q   <= '0;
      pwr_ok_q    <= 1'b0;
      wake_left_q <= WAKE_W'(WAKE_CYCLES);
      init_done_q <= 1'b0;
    end else begin
      if (!pwr_ok_q) begin
        pwr_cnt_q <= pwr_cnt_q + 1'b1;
        if (pwr_cnt_q == PWR_W'(PWRUP_CYC - 1)) pwr_ok_q <= 1'b1;
      end
      if (overrun) begin
        init_done_q <= 1'b0;
        wake_left_q <= WAKE_W'(WAKE_CYCLES);
      end else if (eng_done && !init_done_q && wake_left_q != '0) begin
        wake_left_q <= wake_left_q - 1'b1;
        if (wake_left_q == WAKE_W'(1)) init_done_q <= 1'b1;
      end
    end
  end

  assign ref_req    = eng_busy || (need && !eng_done);
  assign ref_done   = eng_done;
  assign ref_urgent = init_done_q && urgent_raw;
  assign init_done  = init_done_q;
  assign we_n       = 1'b1;

  // R2
  pause_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_ok_q |-> !ref_req);

  // R3
  init_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(init_done_q) |-> $past(eng_done));

  // R4
  start_on_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(eng_busy) |-> $past(ref_grant && ref_req));

  // R12
  rewake_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(init_done_q) |-> ref_req);

endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb_top;

  localparam int CLK = 8;
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  localparam int PWR   = cdiv(800, CLK);
  localparam int REFI  = 400 / CLK;
  localparam int CSR   = cdiv(10, CLK);
  localparam int CHR   = cdiv(10, CLK);
  localparam int ACT   = cdiv(40, CLK);
  localparam int PRE   = cdiv(25, CLK);
  localparam int ASR   = 1;
  localparam int WAKE  = 8;
  localparam int MAXP  = 3;
  localparam int RO_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic grant = 1'b0, grant_ro = 1'b0;
  logic req, done, urgent, initd, ras, casl, cash, we;
  logic [8:0] addr;
  logic req_r, done_r, urgent_r, initd_r, ras_r, casl_r, cash_r, we_r;
  logic [RO_W-1:0] addr_r;

  dram_refresh_seq #(
    .CLK_NS(CLK), .RETENTION_NS(512*400), .ROW_W(9), .PWRUP_NS(800),
    .WAKE_CYCLES(WAKE), .MAX_POSTPONE(MAXP), .RAS_ONLY(1'b0)
  ) dut_i (
    .clk(clk), .rst(rst), .ref_req(req), .ref_grant(grant), .ref_done(done),
    .ref_urgent(urgent), .init_done(initd), .ras_n(ras), .casl_n(casl),
    .cash_n(cash), .we_n(we), .row_addr(addr)
  );

  dram_refresh_seq #(
    .CLK_NS(CLK), .RETENTION_NS(16*400), .ROW_W(RO_W), .PWRUP_NS(800),
    .WAKE_CYCLES(WAKE), .MAX_POSTPONE(MAXP), .RAS_ONLY(1'b1)
  ) dut_ro_i (
    .clk(clk), .rst(rst), .ref_req(req_r), .ref_grant(grant_ro), .ref_done(done_r),
    .ref_urgent(urgent_r), .init_done(initd_r), .ras_n(ras_r), .casl_n(casl_r),
    .cash_n(cash_r), .we_n(we_r), .row_addr(addr_r)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
    end
  endtask

  // Strobe spacing monitor for the CAS-before-RAS instance
  int cas_run = 0, ras_lo_run = 0, ras_hi_run = 0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_done = 1'b0;
  always @(negedge clk) if (!rst) begin
    chk(we == 1'b1, "R8", we, 1);
    if (casl != cash) chk(1'b0, "R5", casl, cash);
    if (p_ras && !ras) chk(cas_run == CSR && !casl, "R5", cas_run, CSR);
    if (!p_cas && casl) chk(ras_lo_run == CHR && !ras, "R6", ras_lo_run, CHR);
    if (!p_ras && ras) chk(ras_lo_run == ACT, "R7", ras_lo_run, ACT);
    if (done) chk(ras_hi_run == PRE && ras, "R7", ras_hi_run, PRE);
    if (p_done) chk(!done, "R9", done, 0);
    cas_run    = !casl ? cas_run + 1 : 0;
    ras_lo_run = !ras ? ras_lo_run + 1 : 0;
    ras_hi_run = ras ? ras_hi_run + 1 : 0;
    p_ras = ras; p_cas = casl; p_done = done;
  end

  // Monitor for the RAS-only instance
  int ro_cycles = 0;
  int exp_row = 0;
  logic pr_ras = 1'b1;
  logic [RO_W-1:0] pr_addr = '0;
  always @(negedge clk) if (!rst) begin
    if (pr_ras && !ras_r) begin
      chk(casl_r && cash_r, "R13", {casl_r, cash_r}, 3);
      chk(int'(addr_r) == exp_row, "R13", addr_r, exp_row);
      chk(pr_addr == addr_r, "R13", pr_addr, addr_r);
      exp_row = (exp_row + 1) % (1 << RO_W);
      ro_cycles++;
    end else if (!ras_r) begin
      chk(casl_r && cash_r && pr_addr == addr_r, "R13", addr_r, pr_addr);
    end
    pr_ras = ras_r; pr_addr = addr_r;
  end

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  // Wait for a request, grant after dly cycles, return on the done sample
  task automatic serve_one(input int dly);
    do @(negedge clk); while (!req);
    repeat (dly) @(negedge clk);
    grant = 1'b1;
    @(negedge clk);
    grant = 1'b0;
    chk(!casl && !cash && ras, "R4", casl, 0);
    do @(negedge clk); while (!done);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(ras && casl && cash && we, "R1", {ras, casl, cash, we}, 15);
    chk(!req && !done && !urgent && !initd, "R1", {req, done, urgent, initd}, 0);
    rst = 1'b0;
    grant_ro = 1'b1;
    for (int k = 1; k <= PWR; k++) begin
      @(negedge clk);
      if (k == PWR - 1) chk(!req, "R2", req, 0);
      if (k == PWR) chk(req, "R2", req, 1);
    end
    for (int i = 0; i < WAKE; i++) begin
      serve_one(int'($urandom % 4));
      chk(!initd, "R3", initd, 0);
    end
    @(negedge clk);
    chk(initd, "R3", initd, 1);
    // Interval, grant without request, postponement and overrun
    for (int k = 1; k <= (MAXP + 1) * REFI; k++) begin
      grant = (k == 1);
      @(negedge clk);
      if (k == 2) chk(ras && casl && !done, "R4", {ras, casl, done}, 6);
      if (k == REFI - 1) chk(!req, "R10", req, 0);
      if (k == REFI) chk(req, "R10", req, 1);
      if (k == MAXP * REFI - 1) chk(!urgent, "R11", urgent, 0);
      if (k == MAXP * REFI) chk(urgent, "R11", urgent, 1);
      if (k == (MAXP + 1) * REFI - 1) chk(initd, "R12", initd, 1);
      if (k == (MAXP + 1) * REFI) begin
        chk(!initd, "R12", initd, 0);
        chk(req && !urgent, "R12", {req, urgent}, 2);
      end
    end
    grant = 1'b0;
    for (int i = 0; i < WAKE; i++) begin
      serve_one(int'($urandom % 3));
      chk(!initd, "R12", initd, 0);
    end
    @(negedge clk);
    chk(initd, "R12", initd, 1);
    // Urgency clears after one service
    do @(negedge clk); while (!urgent);
    serve_one(int'($urandom % 3));
    chk(urgent, "R11", urgent, 1);
    @(negedge clk);
    chk(!urgent, "R11", urgent, 0);
    while (req) serve_one(0);
    // Random grant latency
    for (int i = 0; i < 20; i++) serve_one(int'($urandom % 20));
    chk(initd && !urgent, "R10", {initd, urgent}, 2);
    chk(ro_cycles >= 20, "R13", ro_cycles, 20);
    finish_run();
  end

endmodule